// File: doc/BRIEF.md
# Hysteretic Fast-Detect Flag

This block watches the sample-magnitude stream of a converter datapath and raises a single overrange flag the moment a magnitude rises above an upper limit. The flag then stays up until the signal has spent a programmable run of consecutive valid samples strictly beneath a second, lower limit. The gap between the two limits gives hysteresis, and the run length acts as a dwell timer. Together they stop a gain-control loop or a protection path from chattering on a signal that sits near the limit.

The two 15-bit limits, the 16-bit dwell length and an output enable are written one byte at a time through a plain write port, and the block runs on the sample clock. The exported flag is gated by the enable. A second output always shows the ungated set/clear state. With the parameter `SIGNED_IN` set, the sample port takes 16-bit two's complement samples, and the block forms their saturated absolute value as the magnitude.

Top module: `fast_flag_detect`

## Requirements
- R1: Byte writes with `wr_en_i` high land on the next rising clock edge, and the new value governs samples from the following cycle onward. The write address selects the target as follows. Address 0, bit 0, is the enable. Addresses 1 and 2 are the upper limit: address 1 holds bits [7:0] and address 2, bits [6:0], holds bits [14:8]. Addresses 3 and 4 are the lower limit, laid out the same way. Addresses 5 and 6 are the dwell length, bits [7:0] and bits [15:8]. Bit 7 written to address 2 or 4 is discarded.
- R2: A valid sample whose magnitude is strictly greater than the upper limit sets the state at that clock edge. A magnitude equal to the upper limit does not set it.
- R3: Once set, the state clears at the edge of the N-th consecutive valid sample strictly below the lower limit, where N is the dwell length, or 1 when the dwell length is 0 or 1.
- R4: While set, a valid sample at or above the lower limit that does not exceed the upper limit restarts the below-limit run from zero. A magnitude equal to the lower limit does not count as below.
- R5: A valid sample above the upper limit while a below-limit run is in progress keeps the state set and restarts the run.
- R6: With a dwell length of 0, the first valid sample below the lower limit clears the state.
- R7: Cycles with `sample_vld_i` low leave the state and the run count unchanged, whatever the sample value.
- R8: `flag_o` equals the state while the enable is 1 and is 0 while the enable is 0. `raw_o` shows the state regardless of the enable.
- R9: Reset clears the state, the run count, both limits, the dwell length and the enable. With the upper limit at 0 after reset, any nonzero valid magnitude sets the state.
- R10: With `SIGNED_IN`=1, the magnitude is the absolute value of the 16-bit signed sample, and -32768 saturates to 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register byte write strobe |
| wr_addr_i | input | 3 | Register byte address |
| wr_data_i | input | 8 | Register byte data |
| sample_vld_i | input | 1 | Sample valid strobe |
| sample_i | input | 15 (16 with SIGNED_IN) | Unsigned magnitude, or signed sample |
| flag_o | output | 1 | Enable-gated fast-detect flag |
| raw_o | output | 1 | Ungated detector state |

## Verification
The bench targets values that sit exactly on each limit. A strict-versus-inclusive compare error would set the flag at the upper limit, or would treat a sample equal to the lower limit as part of the clearing run. It breaks runs with in-band samples, with over-limit samples and with idle cycles. A counter that fails to restart would then clear early, and one that counts idle cycles would clear on a gap. It also covers a zero dwell length, the enable gating with the state still tracking, the discarded bit 7 of the high bytes, and the -32768 corner of the signed option, where a plain negation wraps to zero and never trips.

// File: rtl/ffd_pkg.sv
package ffd_pkg;
  localparam int unsigned MAG_W   = 15;
  localparam int unsigned DWELL_W = 16;
  localparam int unsigned ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_UPR_LO = 3'd1,
    REG_UPR_HI = 3'd2,
    REG_LWR_LO = 3'd3,
    REG_LWR_HI = 3'd4,
    REG_DWL_LO = 3'd5,
    REG_DWL_HI = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/ffd_regs.sv
module ffd_regs
  import ffd_pkg::*;
#(
  parameter int unsigned MAG_W   = ffd_pkg::MAG_W,
  parameter int unsigned DWELL_W = ffd_pkg::DWELL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  output logic               en_o,
  output logic [MAG_W-1:0]   upper_o,
  output logic [MAG_W-1:0]   lower_o,
  output logic [DWELL_W-1:0] dwell_o
);
  localparam int unsigned HI_W = MAG_W - 8;

  logic               en_q;
  logic [MAG_W-1:0]   upper_q, lower_q;
  logic [DWELL_W-1:0] dwell_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      upper_q <= '0;
      lower_q <= '0;
      dwell_q <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        REG_CTRL:   en_q                   <= wr_data_i[0];
        REG_UPR_LO: upper_q[7:0]           <= wr_data_i;
        REG_UPR_HI: upper_q[MAG_W-1:8]     <= wr_data_i[HI_W-1:0];
        REG_LWR_LO: lower_q[7:0]           <= wr_data_i;
        REG_LWR_HI: lower_q[MAG_W-1:8]     <= wr_data_i[HI_W-1:0];
        REG_DWL_LO: dwell_q[7:0]           <= wr_data_i;
        REG_DWL_HI: dwell_q[DWELL_W-1:8]   <= wr_data_i[DWELL_W-9:0];
        default: ;
      endcase
    end
  end

  assign en_o    = en_q;
  assign upper_o = upper_q;
  assign lower_o = lower_q;
  assign dwell_o = dwell_q;
endmodule

// File: rtl/ffd_mag.sv
module ffd_mag #(
  parameter int unsigned MAG_W     = ffd_pkg::MAG_W,
  parameter bit          SIGNED_IN = 1'b0,
  localparam int unsigned SMP_W    = MAG_W + (SIGNED_IN ? 1 : 0)
) (
  input  logic [SMP_W-1:0] sample_i,
  output logic [MAG_W-1:0] mag_o
);
  generate
    if (SIGNED_IN) begin : g_abs
      logic [SMP_W-1:0] neg_w;
      logic [SMP_W-1:0] abs_w;
      assign neg_w = ~sample_i + 1'b1;
      assign abs_w = sample_i[SMP_W-1] ? neg_w : sample_i;
      // only the most negative code overflows into the top bit
      assign mag_o = abs_w[SMP_W-1] ? {MAG_W{1'b1}} : abs_w[MAG_W-1:0];
    end else begin : g_pass
      assign mag_o = sample_i;
    end
  endgenerate
endmodule

// File: rtl/ffd_hyst.sv
module ffd_hyst #(
  parameter int unsigned MAG_W   = ffd_pkg::MAG_W,
  parameter int unsigned DWELL_W = ffd_pkg::DWELL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [MAG_W-1:0]   mag_i,
  input  logic [MAG_W-1:0]   upper_i,
  input  logic [MAG_W-1:0]   lower_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic               state_o
);
  logic               state_q;
  logic [DWELL_W-1:0] run_q;
  logic [DWELL_W:0]   run_inc;
  logic               above, below, run_done;

  assign above    = mag_i > upper_i;
  assign below    = mag_i < lower_i;
  assign run_inc  = {1'b0, run_q} + 1'b1;
  assign run_done = run_inc >= {1'b0, dwell_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      run_q   <= '0;
    end else if (vld_i) begin
      if (above) begin
        state_q <= 1'b1;
        run_q   <= '0;
      end else if (state_q && below) begin
        if (run_done) begin
          state_q <= 1'b0;
          run_q   <= '0;
        end else begin
          run_q <= run_inc[DWELL_W-1:0];
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/fast_flag_detect.sv
module fast_flag_detect
  import ffd_pkg::*;
#(
  parameter int unsigned MAG_W     = ffd_pkg::MAG_W,
  parameter int unsigned DWELL_W   = ffd_pkg::DWELL_W,
  parameter bit          SIGNED_IN = 1'b0,
  localparam int unsigned SMP_W    = MAG_W + (SIGNED_IN ? 1 : 0)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              sample_vld_i,
  input  logic [SMP_W-1:0]  sample_i,
  output logic              flag_o,
  output logic              raw_o
);
  logic               en_w;
  logic [MAG_W-1:0]   upper_w, lower_w, mag_w;
  logic [DWELL_W-1:0] dwell_w;
  logic               state_w;

  ffd_regs #(.MAG_W(MAG_W), .DWELL_W(DWELL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en_w), .upper_o(upper_w), .lower_o(lower_w), .dwell_o(dwell_w)
  );

  ffd_mag #(.MAG_W(MAG_W), .SIGNED_IN(SIGNED_IN)) u_mag (
    .sample_i, .mag_o(mag_w)
  );

  ffd_hyst #(.MAG_W(MAG_W), .DWELL_W(DWELL_W)) u_hyst (
    .clk_i, .rst_ni, .vld_i(sample_vld_i), .mag_i(mag_w),
    .upper_i(upper_w), .lower_i(lower_w), .dwell_i(dwell_w),
    .state_o(state_w)
  );

  assign raw_o  = state_w;
  assign flag_o = state_w & en_w;
endmodule

// File: rtl/ffd_checker.sv
module ffd_checker #(
  parameter int unsigned MAG_W = ffd_pkg::MAG_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vld_i,
  input logic [MAG_W-1:0] mag_i,
  input logic [MAG_W-1:0] upper_i,
  input logic [MAG_W-1:0] lower_i,
  input logic             en_i,
  input logic             raw_i,
  input logic             flag_i
);
  // R2, R5
  a_r2_set_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && mag_i > upper_i) |=> raw_i);
  // R7
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(raw_i));
  // R4
  a_r4_inband_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && raw_i && mag_i >= lower_i) |=> raw_i);
  // R3
  a_r3_clear_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(raw_i) |-> $past(vld_i && mag_i < lower_i));
  // R8
  a_r8_flag_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i |-> raw_i);
  a_r8_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !flag_i);
endmodule

bind fast_flag_detect ffd_checker #(.MAG_W(MAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(sample_vld_i), .mag_i(mag_w),
  .upper_i(upper_w), .lower_i(lower_w), .en_i(en_w),
  .raw_i(raw_o), .flag_i(flag_o)
);

// File: tb/sim_fast_flag_detect.sv
module sim_fast_flag_detect;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        v0 = 1'b0, v1 = 1'b0;
  logic [14:0] s0 = '0;
  logic [15:0] s1 = '0;
  logic        flag0, raw0, flag1, raw1;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  fast_flag_detect u0 (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sample_vld_i(v0), .sample_i(s0), .flag_o(flag0), .raw_o(raw0)
  );

  fast_flag_detect #(.SIGNED_IN(1'b1)) u1 (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sample_vld_i(v1), .sample_i(s1), .flag_o(flag1), .raw_o(raw1)
  );

  // {vld, mag, raw, flag}; upper 1000, lower 500, dwell 3, enabled
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 15'd800,  1'b0, 1'b0},  // R2 in band, stays clear
    {1'b1, 15'd1000, 1'b0, 1'b0},  // R2 equal to upper
    {1'b1, 15'd1001, 1'b1, 1'b1},  // R2 set
    {1'b1, 15'd499,  1'b1, 1'b1},  // R3 run 1
    {1'b1, 15'd499,  1'b1, 1'b1},  // R3 run 2
    {1'b1, 15'd600,  1'b1, 1'b1},  // R4 restart
    {1'b1, 15'd400,  1'b1, 1'b1},
    {1'b1, 15'd400,  1'b1, 1'b1},
    {1'b0, 15'd0,    1'b1, 1'b1},  // R7 idle gap
    {1'b1, 15'd500,  1'b1, 1'b1},  // R4 equal to lower restarts
    {1'b1, 15'd0,    1'b1, 1'b1},
    {1'b1, 15'd0,    1'b1, 1'b1},
    {1'b1, 15'd2000, 1'b1, 1'b1},  // R5 restart by upper
    {1'b1, 15'd0,    1'b1, 1'b1},
    {1'b1, 15'd0,    1'b1, 1'b1},
    {1'b1, 15'd0,    1'b0, 1'b0},  // R3 third consecutive clears
    {1'b1, 15'd499,  1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic smp0(input logic [14:0] m);
    v0 = 1'b1; s0 = m;
    @(negedge clk);
    v0 = 1'b0;
  endtask

  task automatic smp1(input logic [15:0] m);
    v1 = 1'b1; s1 = m;
    @(negedge clk);
    v1 = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R9 raw0", raw0, 1'b0);
    chk("R9 flag0", flag0, 1'b0);
    chk("R9 raw1", raw1, 1'b0);
    // R9 zero upper limit and zero enable after reset
    smp0(15'd1);
    chk("R9 raw tracks zero upper", raw0, 1'b1);
    chk("R8 flag gated by reset enable", flag0, 1'b0);

    do_reset();
    chk("R9 raw after second reset", raw0, 1'b0);
    wr(3'd1, 8'hE8); wr(3'd2, 8'h03);
    wr(3'd3, 8'hF4); wr(3'd4, 8'h01);
    wr(3'd5, 8'h03); wr(3'd6, 8'h00);
    wr(3'd0, 8'h01);

    for (int i = 0; i < NV; i++) begin
      v0 = VEC[i][17]; s0 = VEC[i][16:2];
      @(negedge clk);
      v0 = 1'b0;
      chk($sformatf("R1-R7 vec %0d raw", i), raw0, VEC[i][1]);
      chk($sformatf("R8 vec %0d flag", i), flag0, VEC[i][0]);
    end

    // R6 zero dwell
    wr(3'd5, 8'h00);
    smp0(15'd2000);
    chk("R6 set", raw0, 1'b1);
    smp0(15'd10);
    chk("R6 first below clears", raw0, 1'b0);

    // R8 enable gating
    wr(3'd0, 8'h00);
    smp0(15'd2000);
    chk("R8 raw tracks while disabled", raw0, 1'b1);
    chk("R8 flag low while disabled", flag0, 1'b0);
    wr(3'd0, 8'h01);
    chk("R8 flag follows after enable", flag0, 1'b1);
    smp0(15'd10);
    chk("R8 clear seen on flag", flag0, 1'b0);

    // R1 reserved bit 7 of high byte
    wr(3'd1, 8'h10); wr(3'd2, 8'h80);
    smp0(15'd16);
    chk("R1 upper 16, equal does not set", raw0, 1'b0);
    smp0(15'd17);
    chk("R1 bit7 discarded, 17 sets", raw0, 1'b1);
    smp0(15'd0);
    chk("R1 cleared", raw0, 1'b0);

    // R10 signed option
    wr(3'd1, 8'h64); wr(3'd2, 8'h00);
    smp1(16'hFF9C);
    chk("R10 abs(-100) not above 100", raw1, 1'b0);
    smp1(16'hFF9B);
    chk("R10 abs(-101) sets", raw1, 1'b1);
    smp1(16'h0000);
    chk("R10 clear", raw1, 1'b0);
    smp1(16'd101);
    chk("R10 positive 101 sets", raw1, 1'b1);
    smp1(16'h0000);
    wr(3'd1, 8'hFE); wr(3'd2, 8'h7F);
    smp1(16'h8000);
    chk("R10 -32768 saturates above 32766", raw1, 1'b1);
    chk("R10 u0 untouched by u1 samples", raw0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule